// File: doc/BRIEF.md
# Serial Control Port Register Slave

This block gives an external host read and write access to a bank of 8-bit control registers over a four-wire synchronous serial link. The pins are a serial clock, an active-low chip select, serial data in, and serial data out with a separate output-enable. The pad logic outside the block turns that enable into a high-impedance driver. Every access is one 16-bit frame. The frame opens with a direction bit (1 = read, 0 = write), then carries the address MSB first, then the data byte MSB first. Serial input is sampled on rising serial-clock edges. Serial output changes on falling edges.

The block is clocked directly by the serial clock. Chip select high clears the frame state asynchronously, so an aborted frame leaves nothing behind. A write lands in the bank only on the 16th rising edge. A read turns the output on at the falling edge that follows the last address bit. One register carries a soft-reset bit. While that bit is 1 the rest of the bank is held at zero.

Top module: `scpSlave`

## Requirements
- R1: Bit 0 of a frame is the direction (0 = write, 1 = read), bits 1..7 are the address A6..A0, and bits 8..15 are the data D7..D0, each sampled on a rising serial-clock edge. A complete write stores that byte at that address.
- R2: A register changes only on the 16th rising edge after chip select falls. If chip select rises after fewer than 16 rising edges, no register changes.
- R3: In a read frame, output enable goes high on the falling edge after the 8th rising edge. The output presents D7 on that falling edge and D6..D0 on the next seven falling edges. Before that edge the output enable is low.
- R4: In a write frame the output enable stays low for the whole frame.
- R5: While chip select is high, the output enable is low and the frame bit count is zero. Both clear at once when chip select rises.
- R6: Addresses 24..127 are unimplemented. A read of one returns 0x00 and a write to one changes nothing.
- R7: After the hardware reset, register 11 holds 0x40 and all other registers hold 0x00.
- R8: Bit 6 of register 11 is the soft reset. While it is 1, every other register reads 0x00 and writes to them are ignored. Writing 0 to it releases the bank. Writing 1 to it clears the bank.
- R9: Rising edges after the 16th in the same frame are ignored: the count holds at 16 and the committed value comes from the first 16 bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select, one falling edge per frame |
| sdi | input | 1 | Serial data from the host, sampled on rising edges |
| sdoData | output | 1 | Serial read data, changes on falling edges |
| sdoOe | output | 1 | Output enable for the external tri-state driver of sdoData |

## Verification
The hardest situation to reach from the pins is a frame that breaks the 16-clock rule. That covers chip select rising after 15 or fewer edges, and chip select held low past the 17th edge. Either case must leave the bank untouched or hold the count at 16. The stimulus mixes randomly truncated and randomly extended frames into a seeded random stream of reads and writes. Some of those writes hit the soft-reset register and some hit unimplemented addresses. A bench model of the bank predicts every read-back.

// File: rtl/scpPkg.sv
package scpPkg;
  // strobes from the frame counter to the datapath
  typedef struct packed {
    logic sampleEn;  // rising edge takes a bit from sdi
    logic commit;    // rising edge completing the 16th bit
    logic loadOut;   // falling edge after the last address bit
    logic shiftOut;  // falling edges presenting the lower data bits
  } scpStrobe_t;
endpackage

// File: rtl/scpControl.sv
module scpControl
  import scpPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(1 + ADDR_W + DATA_W + 1)
) (
  input  logic             sclk,
  input  logic             frameClr,
  output logic [CNT_W-1:0] bitCnt,
  output scpStrobe_t       strobe
);
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(1 + ADDR_W);

  always_ff @(posedge sclk or posedge frameClr) begin
    if (frameClr) bitCnt <= '0;
    else if (bitCnt != CNT_FULL) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.sampleEn = (bitCnt < CNT_FULL);
    strobe.commit   = (bitCnt == CNT_LAST);
    strobe.loadOut  = (bitCnt == CNT_HDR);
    strobe.shiftOut = (bitCnt > CNT_HDR) && (bitCnt < CNT_FULL);
  end
endmodule

// File: rtl/scpDatapath.sv
module scpDatapath
  import scpPkg::*;
#(
  parameter int NUM_REGS  = 24,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int SRST_ADDR = 11,
  parameter int SRST_BIT  = 6
) (
  input  logic       sclk,
  input  logic       rstN,
  input  logic       frameClr,
  input  logic       sdi,
  input  scpStrobe_t strobe,
  output logic       sdoData,
  output logic       sdoOe
);
  localparam int SHIFT_W = ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] SRST_A    = ADDR_W'(SRST_ADDR);
  localparam logic [DATA_W-1:0] SRST_INIT = DATA_W'(1) << SRST_BIT;

  logic [SHIFT_W-1:0] shiftQ;
  logic [DATA_W-1:0]  bank [NUM_REGS];
  logic [DATA_W-1:0]  outQ;
  logic               oeQ;

  // incoming bits, cleared whenever the frame is closed
  always_ff @(posedge sclk or posedge frameClr) begin
    if (frameClr) shiftQ <= '0;
    else if (strobe.sampleEn) shiftQ <= {shiftQ[SHIFT_W-2:0], sdi};
  end

  // write decode on the edge that brings in D0
  logic              doWrite;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              srstHit;
  logic              srstActive;
  assign wrAddr     = shiftQ[SHIFT_W-2 -: ADDR_W];
  assign wrData     = {shiftQ[DATA_W-2:0], sdi};
  assign doWrite    = strobe.commit & ~shiftQ[SHIFT_W-1];
  assign srstHit    = doWrite && (wrAddr == SRST_A);
  assign srstActive = bank[SRST_ADDR][SRST_BIT] | (srstHit & wrData[SRST_BIT]);

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++)
        bank[i] <= (i == SRST_ADDR) ? SRST_INIT : '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (i == SRST_ADDR) begin
          if (srstHit) bank[i] <= wrData;
        end else if (srstActive) begin
          bank[i] <= '0;
        end else if (doWrite && wrAddr == ADDR_W'(i)) begin
          bank[i] <= wrData;
        end
      end
    end
  end

  // read fetch: address is complete once the header has arrived
  logic              rdDir;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdValue;
  assign rdDir  = shiftQ[ADDR_W];
  assign rdAddr = shiftQ[ADDR_W-1:0];

  always_comb begin
    rdValue = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdValue = bank[i];
  end

  always_ff @(negedge sclk or posedge frameClr) begin
    if (frameClr) begin
      outQ <= '0;
      oeQ  <= 1'b0;
    end else if (strobe.loadOut) begin
      outQ <= rdValue;
      oeQ  <= rdDir;
    end else if (strobe.shiftOut) begin
      outQ <= {outQ[DATA_W-2:0], 1'b0};
    end
  end

  assign sdoData = outQ[DATA_W-1];
  assign sdoOe   = oeQ;
endmodule

// File: rtl/scpSlave.sv
module scpSlave
  import scpPkg::*;
#(
  parameter int NUM_REGS  = 24,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int SRST_ADDR = 11,
  parameter int SRST_BIT  = 6
) (
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdi,
  output logic sdoData,
  output logic sdoOe
);
  localparam int CNT_W = $clog2(1 + ADDR_W + DATA_W + 1);

  logic             frameClr;
  logic [CNT_W-1:0] bitCnt;
  scpStrobe_t       strobe;

  assign frameClr = csN | ~rstN;

  scpControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .sclk(sclk), .frameClr(frameClr), .bitCnt(bitCnt), .strobe(strobe)
  );

  scpDatapath #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SRST_ADDR(SRST_ADDR), .SRST_BIT(SRST_BIT)
  ) uData (
    .sclk(sclk), .rstN(rstN), .frameClr(frameClr), .sdi(sdi),
    .strobe(strobe), .sdoData(sdoData), .sdoOe(sdoOe)
  );
endmodule

// File: rtl/scpSlaveChecker.sv
module scpSlaveChecker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic             rstN,
  input logic             sclk,
  input logic             csN,
  input logic             sdi,
  input logic             sdoOe,
  input logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 + ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] HDR  = CNT_W'(1 + ADDR_W);

  logic             clr;
  logic [CNT_W-1:0] edgeCnt;
  logic             isRead;
  assign clr = csN | ~rstN;

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      edgeCnt <= '0;
      isRead  <= 1'b0;
    end else begin
      if (edgeCnt == '0) isRead <= sdi;
      if (edgeCnt != FULL) edgeCnt <= edgeCnt + 1'b1;
    end
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge sclk) disable iff (!rstN)
    csN |-> !sdoOe);  // R5
  AST_HEADER_NO_DRIVE: assert property (@(posedge sclk) disable iff (clr)
    (edgeCnt < HDR) |-> !sdoOe);  // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge sclk) disable iff (clr)
    (edgeCnt != '0 && !isRead) |-> !sdoOe);  // R4
  AST_COUNT_TRACK: assert property (@(posedge sclk) disable iff (!rstN)
    bitCnt == edgeCnt);  // R9
endmodule

bind scpSlave scpSlaveChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .sdoOe(sdoOe), .bitCnt(bitCnt)
);

// File: tb/scpSlave_test.sv
`timescale 1ns/1ps
module scpSlave_test;
  localparam int NREG = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic sdoData, sdoOe;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] mdl [128];

  always #4 clk = ~clk;

  scpSlave uut (.rstN(rstN), .sclk(clk), .csN(csN), .sdi(sdi),
                .sdoData(sdoData), .sdoOe(sdoOe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [6:0] a);
    return (a < NREG) ? mdl[a] : 8'h00;
  endfunction

  function automatic void mdlWrite(input logic [6:0] a, input logic [7:0] d);
    if (a >= NREG) return;
    if (a == 11) begin
      mdl[11] = d;
      if (d[6]) for (int i = 0; i < NREG; i++) if (i != 11) mdl[i] = 8'h00;
    end else if (!mdl[11][6]) mdl[a] = d;
  endfunction

  // one frame of nclk rising edges; reports read byte and enable errors
  task automatic doFrame(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                         input int nclk, output logic [7:0] got,
                         output bit oeErr, output bit offErr);
    logic [15:0] frm;
    logic expOe;
    frm = {rd, a, wd};
    got = 8'h00; oeErr = 0; offErr = 0;
    @(negedge clk); #1;
    csN = 1'b0;
    for (int k = 0; k < nclk; k++) begin
      sdi = (k < 16) ? frm[15-k] : 1'($urandom);
      #1;
      if (k >= 8 && k < 16) got[15-k] = sdoData;
      expOe = (k >= 8) ? rd : 1'b0;
      if (sdoOe !== expOe) oeErr = 1;
      @(posedge clk);
      if (k != nclk - 1) begin @(negedge clk); #1; end
    end
    #2 csN = 1'b1;
    #1 if (sdoOe !== 1'b0) offErr = 1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int n, input string req);
    logic [7:0] g; bit e1, e2;
    doFrame(1'b0, a, d, n, g, e1, e2);
    if (n >= 16) mdlWrite(a, d);
    check(!e1, {req, " R4 write output enable"}, e1, 0);
    check(!e2, "R5 enable off after chip select", e2, 0);
  endtask

  task automatic rdChk(input logic [6:0] a, input string req);
    logic [7:0] g; bit e1, e2;
    doFrame(1'b1, a, 8'($urandom), 16, g, e1, e2);
    check(g == expRead(a), {req, " read data"}, g, expRead(a));
    check(!e1, "R3 read output enable timing", e1, 0);
    check(!e2, "R5 enable off after chip select", e2, 0);
  endtask

  initial begin
    #1_200_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl[11] = 8'h40;
    repeat (3) @(negedge clk);
    #1 check(sdoOe === 1'b0, "R5 enable low in reset", sdoOe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    rdChk(7'd11, "R7 soft reset register after reset");
    rdChk(7'd0, "R7 register 0 after reset");
    wr(7'd5, 8'hA5, 16, "R8 write while held");
    rdChk(7'd5, "R8 held register ignores write");
    wr(7'd11, 8'h00, 16, "R8 release");
    rdChk(7'd11, "R8 release value");
    wr(7'd5, 8'hA5, 16, "R1");
    rdChk(7'd5, "R1 write then read");
    wr(7'd5, 8'h3C, 15, "R2 short");
    rdChk(7'd5, "R2 15-edge frame discarded");
    wr(7'd5, 8'h81, 1, "R2 one edge");
    rdChk(7'd5, "R2 1-edge frame discarded");
    wr(7'd100, 8'hFF, 16, "R6");
    rdChk(7'd100, "R6 unimplemented read");
    rdChk(7'd127, "R6 top address read");
    wr(7'd6, 8'h5A, 20, "R9");
    rdChk(7'd6, "R9 extra edges ignored");
    wr(7'd11, 8'h40, 16, "R8 assert");
    rdChk(7'd5, "R8 bank cleared by soft reset");
    wr(7'd11, 8'h00, 16, "R8 release again");
    wr(7'd23, 8'hC3, 16, "R1 last register");
    rdChk(7'd23, "R1 last register readback");

    for (int n = 0; n < 400; n++) begin
      logic [6:0] a;
      int sel, len;
      a = ($urandom % 4 != 0) ? 7'($urandom % NREG) : 7'($urandom);
      if (a == 11 && ($urandom % 4 != 0)) a = 7'd12;
      sel = $urandom % 10;
      len = (sel == 0) ? 1 + $urandom % 15 : (sel == 1) ? 17 + $urandom % 4 : 16;
      if ($urandom % 2 == 0) wr(a, 8'($urandom), len, (len < 16) ? "R2 random" : "R9 random");
      else rdChk(a, (a >= NREG) ? "R6 random" : "R1 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule